// File: doc/BRIEF.md
# Wired-Mode Interrupt Aggregator

The aggregator gathers a bank of interrupt source lines into one wired interrupt for a parent controller. Each source passes through a two-stage synchronizer. When it fires, it latches a bit in a pending cause register. A per-source mask decides which pending bits can raise the output, and the output is registered.

Software reaches four registers over a simple synchronous bus. Writes take effect on the clock edge where `wr_i` is high. Read data is combinational from the address.

One control bit switches every source at once between level capture and rising-edge capture. A second control bit is only stored and read back; it has no effect on the wired output.

Pending bits are cleared by writing zeros to the cause register. Software can raise a source again through a separate set-cause register.

Top module: `irq_wire_agg`

## Requirements
- R1: After reset the cause register is 0, the mask register is 0xFFFFFFFF, the control register is 0 and `irq_o` is low.
- R2: The registers decode at byte offsets 0x00 (cause), 0x08 (set-cause), 0x10 (mask) and 0x28 (control). `rdata_o` follows `addr_i` combinationally. The set-cause offset and every unmapped offset read 0.
- R3: Control bit 3 selects the capture mode for all sources: 1 is rising-edge and 0 is level. Control bit 5 is stored and read back with no other effect. All other control bits read 0.
- R4: In level mode a cause bit is set on every cycle its synchronized input is high. A change on `src_i` driven before clock edge k appears in the cause register after edge k+2.
- R5: In edge mode a cause bit is set only on a 0-to-1 transition of its synchronized input. An input held high does not set the bit again after it is cleared.
- R6: A write to the cause register updates it to old value AND write data. Writing 0 clears a bit and writing 1 leaves it unchanged.
- R7: Writing 1 to a bit of the set-cause register sets the matching cause bit on that write edge.
- R8: A hardware set event for a bit on the same edge as a software clear of that bit wins, so the bit stays set.
- R9: A 1 in the mask register masks its source. `irq_o` is the OR of cause AND NOT mask, registered one cycle. Reading the cause register returns the raw pending bits regardless of the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NSRC | Interrupt source lines, asynchronous |
| addr_i | input | AW | Register byte address |
| wr_i | input | 1 | Write enable |
| wdata_i | input | NSRC | Write data |
| rdata_o | output | NSRC | Read data for `addr_i` |
| irq_o | output | 1 | Wired interrupt to the parent controller |

## Verification
The assertions assume that `addr_i`, `wr_i` and `wdata_i` are stable around each clock edge and that one write happens per cycle. They relate cause updates only to writes seen on those inputs and to the synchronized source samples. The bench keeps to this by changing every input at the falling edge and holding `wr_i` high for exactly one cycle per access. Source pulses last at least one full cycle so that the synchronizer always captures them.

// File: rtl/irq_wire_agg.sv
module irq_wire_agg #(
  parameter int NSRC = 32,
  parameter int AW   = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic [AW-1:0]   addr_i,
  input  logic            wr_i,
  input  logic [NSRC-1:0] wdata_i,
  output logic [NSRC-1:0] rdata_o,
  output logic            irq_o
);
  localparam logic [AW-1:0] A_CAUSE = AW'(8'h00);
  localparam logic [AW-1:0] A_SETC  = AW'(8'h08);
  localparam logic [AW-1:0] A_MASK  = AW'(8'h10);
  localparam logic [AW-1:0] A_CTRL  = AW'(8'h28);
  localparam int B_EDGE = 3;
  localparam int B_MSI  = 5;

  logic [NSRC-1:0] sync1, sync2, prev, cause, mask, hw_set;
  logic edge_mode, msi_mask, irq_q;

  wire wr_cause = wr_i && addr_i == A_CAUSE;
  wire wr_set   = wr_i && addr_i == A_SETC;
  wire wr_mask  = wr_i && addr_i == A_MASK;
  wire wr_ctrl  = wr_i && addr_i == A_CTRL;

  assign hw_set = edge_mode ? (sync2 & ~prev) : sync2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1     <= '0;
      sync2     <= '0;
      prev      <= '0;
      cause     <= '0;
      mask      <= '1;
      edge_mode <= 1'b0;
      msi_mask  <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      sync1 <= src_i;
      sync2 <= sync1;
      prev  <= sync2;
      cause <= (wr_cause ? (cause & wdata_i) : cause) | hw_set
             | (wr_set ? wdata_i : '0);
      if (wr_mask) mask <= wdata_i;
      if (wr_ctrl) begin
        edge_mode <= wdata_i[B_EDGE];
        msi_mask  <= wdata_i[B_MSI];
      end
      irq_q <= |(cause & ~mask);
    end
  end

  assign irq_o = irq_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CAUSE: rdata_o = cause;
      A_MASK:  rdata_o = mask;
      A_CTRL: begin
        rdata_o[B_EDGE] = edge_mode;
        rdata_o[B_MSI]  = msi_mask;
      end
      default: rdata_o = '0;
    endcase
  end
endmodule

module irq_wire_agg_chk #(
  parameter int NSRC = 32,
  parameter int AW   = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   addr_i,
  input logic            wr_i,
  input logic [NSRC-1:0] wdata_i,
  input logic            irq_o,
  input logic [NSRC-1:0] cause,
  input logic [NSRC-1:0] mask,
  input logic [NSRC-1:0] sync2,
  input logic [NSRC-1:0] prev,
  input logic [NSRC-1:0] hw_set,
  input logic            edge_mode
);
  wire wc = wr_i && addr_i == AW'(8'h00);
  wire ws = wr_i && addr_i == AW'(8'h08);

  a_r9_irq_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (|(cause & ~mask)) |=> irq_o);
  a_r9_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(cause & ~mask)) |=> !irq_o);
  a_r7_set_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ws |=> ((cause & $past(wdata_i)) == $past(wdata_i)));
  a_r6_and_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wc && hw_set == '0) |=> (cause == ($past(cause) & $past(wdata_i))));
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !wc |=> ((cause & $past(cause)) == $past(cause)));
  a_r8_hw_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_set != '0) |=> ((cause & $past(hw_set)) == $past(hw_set)));
  a_r5_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && !ws) |=> ((cause & ~$past(cause) & ~($past(sync2) & ~$past(prev))) == '0));
endmodule

bind irq_wire_agg irq_wire_agg_chk #(.NSRC(NSRC), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wr_i(wr_i), .wdata_i(wdata_i),
  .irq_o(irq_o), .cause(cause), .mask(mask), .sync2(sync2), .prev(prev),
  .hw_set(hw_set), .edge_mode(edge_mode)
);

// File: tb/test_irq_wire_agg.sv
module test_irq_wire_agg;
  localparam logic [5:0] A_CAUSE = 6'h00, A_SETC = 6'h08, A_MASK = 6'h10, A_CTRL = 6'h28;
  localparam int NV = 6;
  localparam logic        V_EDGE [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
  localparam logic [31:0] V_SRC  [NV] = '{32'h0000_0001, 32'h0000_00F0, 32'hA5A5_0000,
                                          32'h0000_0003, 32'h8000_0000, 32'hFFFF_FFFF};
  localparam logic [31:0] V_MASK [NV] = '{32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'h0000_FFFF,
                                          32'h0000_0003, 32'h7FFF_FFFF, 32'h0000_0000};
  localparam logic        V_IRQ  [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1};

  logic clk = 0, rst_n = 0, wr = 0, irq;
  logic [31:0] src = '0, wdata = '0, rdata;
  logic [5:0] addr = '0;
  int total = 0, bad = 0;
  bit finished = 0;

  always #5ns clk = ~clk;

  irq_wire_agg i_irq_wire_agg (.clk(clk), .rst_n(rst_n), .src_i(src), .addr_i(addr),
    .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [5:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic rd_chk(string req, logic [5:0] a, logic [31:0] exp);
    addr = a; #1ns; chk(req, rdata, exp);
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2ms;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    wait_n(3); rst_n = 1; wait_n(1);
    // R1 reset state
    rd_chk("R1 cause", A_CAUSE, 32'h0);
    rd_chk("R1 mask", A_MASK, 32'hFFFF_FFFF);
    rd_chk("R1 ctrl", A_CTRL, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    // R2 set-cause and unmapped read 0
    rd_chk("R2 setc", A_SETC, 32'h0);
    rd_chk("R2 unmapped", 6'h04, 32'h0);

    // vector table: R4 level, R5 edge, R9 masking
    for (int i = 0; i < NV; i++) begin
      wr_reg(A_CTRL, {28'b0, V_EDGE[i], 3'b0});
      wr_reg(A_MASK, V_MASK[i]);
      wr_reg(A_CAUSE, 32'h0);
      @(negedge clk); src = V_SRC[i];
      @(negedge clk); src = '0;
      wait_n(4);
      rd_chk(V_EDGE[i] ? "R5 vec cause" : "R4 vec cause", A_CAUSE, V_SRC[i]);
      chk("R9 vec irq", {31'b0, irq}, {31'b0, V_IRQ[i]});
      wr_reg(A_CAUSE, 32'h0);
      wait_n(3);
    end

    // R4 timing: appears after third edge
    wr_reg(A_CTRL, 32'h0); wr_reg(A_MASK, 32'hFFFF_FFFF); wr_reg(A_CAUSE, 32'h0);
    src = 32'h10; wait_n(2);
    rd_chk("R4 not yet", A_CAUSE, 32'h0);
    wait_n(1);
    rd_chk("R4 latched", A_CAUSE, 32'h10);
    // R8 level: clear while high stays set
    wr_reg(A_CAUSE, 32'h0);
    rd_chk("R8 level clear loses", A_CAUSE, 32'h10);
    src = '0; wait_n(3); wr_reg(A_CAUSE, 32'h0);
    rd_chk("R6 cleared", A_CAUSE, 32'h0);

    // R5 held high in edge mode does not re-set
    wr_reg(A_CTRL, 32'h8);
    src = 32'h80; wait_n(4);
    rd_chk("R5 edge set", A_CAUSE, 32'h80);
    wr_reg(A_CAUSE, 32'h0); wait_n(4);
    rd_chk("R5 held no reset", A_CAUSE, 32'h0);
    src = '0; wait_n(3);

    // R8 edge event on same edge as clear
    @(negedge clk); src = 32'h200;
    wait_n(2); addr = A_CAUSE; wdata = 32'h0; wr = 1;
    @(negedge clk); wr = 0;
    rd_chk("R8 edge vs clear", A_CAUSE, 32'h200);
    src = '0; wr_reg(A_CAUSE, 32'h0);

    // R7 set-cause, R6 AND semantics
    wr_reg(A_SETC, 32'h8000_0001);
    rd_chk("R7 setc", A_CAUSE, 32'h8000_0001);
    rd_chk("R2 setc reads 0", A_SETC, 32'h0);
    wr_reg(A_CAUSE, 32'hFFFF_FFFE);
    rd_chk("R6 ones keep", A_CAUSE, 32'h8000_0000);

    // R9 masked raw read and registered unmask
    wait_n(1);
    chk("R9 masked irq", {31'b0, irq}, 32'h0);
    rd_chk("R9 raw cause", A_CAUSE, 32'h8000_0000);
    wr_reg(A_MASK, 32'h7FFF_FFFF);
    chk("R9 irq delay", {31'b0, irq}, 32'h0);
    wait_n(1);
    chk("R9 irq up", {31'b0, irq}, 32'h1);
    wr_reg(A_MASK, 32'hFFFF_FFFF); wait_n(1);
    chk("R9 irq down", {31'b0, irq}, 32'h0);

    // R3 control bits
    wr_reg(A_CTRL, 32'hFFFF_FFFF);
    rd_chk("R3 ctrl bits", A_CTRL, 32'h28);
    wr_reg(A_CTRL, 32'h20);
    rd_chk("R3 msi only", A_CTRL, 32'h20);
    wr_reg(A_CAUSE, 32'h0);
    src = 32'h4; wait_n(3); wr_reg(A_CAUSE, 32'h0);
    rd_chk("R3 level with msi bit", A_CAUSE, 32'h4);
    src = '0;

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule